// File: doc/BRIEF.md
# Cyclic Deterministic Element Selector

This block drives the unit-element switches of a thermometer-coded DAC so that every input code can be produced several times, each time by a different group of physical elements. The N = 2^n elements form a logical ring, so the last element sits next to the first. For a code k and a sample index s, the block turns on k neighbouring elements. The run of enabled elements begins at one of p starting points that are spread evenly around the ring, q = N/p elements apart. The choice is fixed by k and s alone: it uses no randomness and keeps no memory of earlier codes.

The block has two ways of working. In direct mode, each request presents a code and a sample index, and the matching pattern appears on the element-enable output one cycle later. In sequencing mode, a single start pulse makes the block walk through all N·p patterns on its own. The sample index is the inner loop and the code is the outer loop. A done flag marks the end of the walk.

Top module: `cyclic_dem_selector`

## Requirements
- R1: After reset, `elemEn` is all zero, and `patValid` and `done` are low.
- R2: Element j (numbered 1..N) is driven by bit j-1 of `elemEn`. A direct request (`start`=1, `seqMode`=0, while no sweep is running) loads a pattern. The pattern turns on exactly min(k,N) bits, beginning at bit s·q, where s is the 0-based `sampleIn`, and running upward, wrapping from bit N-1 back to bit 0. The pattern appears after the next clock edge, together with `patValid`=1.
- R3: Code 0 gives an all-zero pattern. Any code of N or more turns on every element.
- R4: A pattern depends only on the code and sample index of its own request. Presenting the same request again after other requests gives the same pattern.
- R5: `patValid` is high for exactly one cycle per loaded pattern. When no pattern is loaded, `elemEn` holds its last value.
- R6: A start with `seqMode`=1 produces N·p patterns in back-to-back cycles, the first one appearing after the edge that follows the start edge. The sample index goes from 0 to p-1 for each code before the code steps on, and the codes run from 1 to N.
- R7: `done` rises in the same cycle that the last sequenced pattern (code N, sample p-1) appears. It stays high until the next accepted start of either mode clears it.
- R8: A `start` that arrives during a sweep, in either mode, has no effect on the sweep.
- R9: With n=4 and p=4, code 5 at sample index 1 enables elements 5 through 9, which gives `elemEn` = 16'h01F0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe: one pattern in direct mode, a whole sweep in sequencing mode |
| seqMode | input | 1 | 0 selects direct mode, 1 selects sequencing mode |
| codeIn | input | N_BITS+1 | Code k for direct mode (0..N; larger values saturate to N) |
| sampleIn | input | log2(p) | 0-based sample index for direct mode |
| elemEn | output | 2^N_BITS | Element enables; bit j-1 drives element j |
| patValid | output | 1 | High for one cycle when a new pattern is on `elemEn` |
| done | output | 1 | Set when a sweep has finished |

## Verification
Direct mode is swept over every code the input can carry, from 0 up past N into the saturating range, at every sample index. The sweep runs first in ascending order and then in descending order. Comparing the two orders separates a pattern that depends only on its own request from one that leaks state from an earlier request, and it also covers the empty, full and wrapping runs. Sequencing mode is run twice: once on its own, and once with stray start pulses injected part way through. The first run fixes the order of the walk and the timing of the done flag. The second run shows that a busy sweep ignores further starts. Idle cycles placed between requests show that the pattern holds its value and that the valid strobe lasts only one cycle.

// File: rtl/dem_sel_pkg.sv
package dem_sel_pkg;
  typedef struct packed {
    logic load;   // datapath registers a new pattern
    logic last;   // this is the final step of a sweep
  } ctrlStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } selState_t;
endpackage

// File: rtl/dem_sel_ctrl.sv
module dem_sel_ctrl
  import dem_sel_pkg::*;
#(
  parameter int N_BITS  = 4,
  parameter int SAMPLES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    seqMode,
  input  logic [N_BITS:0]         codeIn,
  input  logic [(SAMPLES > 1 ? $clog2(SAMPLES) : 1)-1:0] sampleIn,
  output ctrlStrobe_t             strobe,
  output logic [N_BITS:0]         codeOut,
  output logic [(SAMPLES > 1 ? $clog2(SAMPLES) : 1)-1:0] sampleOut,
  output logic                    done
);
  localparam int NUM_ELEM = 1 << N_BITS;
  localparam int CODE_W   = N_BITS + 1;
  localparam int SAMP_W   = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;

  selState_t           state;
  logic [CODE_W-1:0]   kCnt;
  logic [SAMP_W-1:0]   dCnt;
  logic                lastStep;
  logic                dWrap;

  assign dWrap    = (dCnt == SAMP_W'(SAMPLES - 1));
  assign lastStep = (state == ST_RUN) && dWrap && (kCnt == CODE_W'(NUM_ELEM));

  always_comb begin
    strobe.load = (state == ST_RUN) || (start && !seqMode);
    strobe.last = lastStep;
    codeOut     = (state == ST_RUN) ? kCnt : codeIn;
    sampleOut   = (state == ST_RUN) ? dCnt : sampleIn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      kCnt  <= '0;
      dCnt  <= '0;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            done <= 1'b0;
            if (seqMode) begin
              state <= ST_RUN;
              kCnt  <= CODE_W'(1);
              dCnt  <= '0;
            end
          end
        end
        ST_RUN: begin
          if (dWrap) begin
            dCnt <= '0;
            kCnt <= kCnt + CODE_W'(1);
          end else begin
            dCnt <= dCnt + SAMP_W'(1);
          end
          if (lastStep) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: every running cycle issues a pattern load
  p_run_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> strobe.load);

  // R6: sequenced codes stay within 1..N
  p_code_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (kCnt >= CODE_W'(1) && kCnt <= CODE_W'(NUM_ELEM)));

  // R8: a running sweep only stops at its last step
  p_no_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !strobe.last) |=> (state == ST_RUN));

  // R7: done only rises right after the final step
  p_done_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(strobe.last));

  // R7: done is never set while a sweep is running
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == ST_IDLE));
endmodule

// File: rtl/dem_sel_datapath.sv
module dem_sel_datapath
  import dem_sel_pkg::*;
#(
  parameter int N_BITS  = 4,
  parameter int SAMPLES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctrlStrobe_t             strobe,
  input  logic [N_BITS:0]         codeSel,
  input  logic [(SAMPLES > 1 ? $clog2(SAMPLES) : 1)-1:0] sampleSel,
  output logic [(1 << N_BITS)-1:0] elemEn,
  output logic                    patValid
);
  localparam int NUM_ELEM = 1 << N_BITS;
  localparam int STRIDE   = NUM_ELEM / SAMPLES;
  localparam int CODE_W   = N_BITS + 1;

  logic [NUM_ELEM-1:0]   therm;
  logic [N_BITS-1:0]     rotAmt;
  logic [2*NUM_ELEM-1:0] dbl;
  logic [NUM_ELEM-1:0]   rotated;

  // thermometer mask: bit i on when the code exceeds i (saturates above N)
  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_therm
    assign therm[i] = (codeSel > CODE_W'(i));
  end

  // start element offset: sample index times the ring stride
  assign rotAmt  = N_BITS'(sampleSel) * N_BITS'(STRIDE);
  assign dbl     = {therm, therm} << rotAmt;
  assign rotated = dbl[2*NUM_ELEM-1:NUM_ELEM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elemEn   <= '0;
      patValid <= 1'b0;
    end else begin
      patValid <= strobe.load;
      if (strobe.load) elemEn <= rotated;
    end
  end

  // R2/R3: a fresh pattern carries the saturated code's number of ones
  p_ones_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> ($countones(elemEn) ==
      (($past(codeSel) > CODE_W'(NUM_ELEM)) ? NUM_ELEM : int'($past(codeSel)))));

  // R2: a partial run always includes its starting element
  p_start_elem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && codeSel != '0) |=> elemEn[$past(rotAmt)]);

  // R5: pattern holds when nothing is loaded
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> ($stable(elemEn) && !patValid));
endmodule

// File: rtl/cyclic_dem_selector.sv
module cyclic_dem_selector
  import dem_sel_pkg::*;
#(
  parameter int N_BITS  = 4,
  parameter int SAMPLES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    seqMode,
  input  logic [N_BITS:0]         codeIn,
  input  logic [(SAMPLES > 1 ? $clog2(SAMPLES) : 1)-1:0] sampleIn,
  output logic [(1 << N_BITS)-1:0] elemEn,
  output logic                    patValid,
  output logic                    done
);
  localparam int SAMP_W = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;

  initial begin
    if ((1 << N_BITS) % SAMPLES != 0)
      $error("SAMPLES must divide the element count");
  end

  ctrlStrobe_t       strobe;
  logic [N_BITS:0]   codeSel;
  logic [SAMP_W-1:0] sampleSel;

  dem_sel_ctrl #(.N_BITS(N_BITS), .SAMPLES(SAMPLES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .seqMode   (seqMode),
    .codeIn    (codeIn),
    .sampleIn  (sampleIn),
    .strobe    (strobe),
    .codeOut   (codeSel),
    .sampleOut (sampleSel),
    .done      (done)
  );

  dem_sel_datapath #(.N_BITS(N_BITS), .SAMPLES(SAMPLES)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .codeSel   (codeSel),
    .sampleSel (sampleSel),
    .elemEn    (elemEn),
    .patValid  (patValid)
  );
endmodule

// File: tb/sim_cyclic_dem_selector.sv
`timescale 1ns/1ps
module sim_cyclic_dem_selector;
  localparam int NB = 4;
  localparam int P  = 4;
  localparam int N  = 1 << NB;
  localparam int Q  = N / P;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          seqMode = 1'b0;
  logic [NB:0]   codeIn = '0;
  logic [1:0]    sampleIn = '0;
  logic [N-1:0]  elemEn;
  logic          patValid;
  logic          done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cyclic_dem_selector #(.N_BITS(NB), .SAMPLES(P)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .seqMode(seqMode),
    .codeIn(codeIn), .sampleIn(sampleIn),
    .elemEn(elemEn), .patValid(patValid), .done(done)
  );

  function automatic logic [N-1:0] expPat(int k, int s);
    logic [N-1:0] r = '0;
    int cnt = (k > N) ? N : k;
    for (int j = 0; j < cnt; j++) r[(s * Q + j) % N] = 1'b1;
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // direct request, then one idle cycle
  task automatic directReq(int k, int s, string req);
    logic [N-1:0] held;
    @(negedge clk);
    start = 1'b1; seqMode = 1'b0; codeIn = (NB+1)'(k); sampleIn = 2'(s);
    @(posedge clk); #1;
    chk(req, {16'h0, elemEn}, {16'h0, expPat(k, s)});
    chk("R5 valid", {31'h0, patValid}, 32'h1);
    held = elemEn;
    @(negedge clk);
    start = 1'b0;
    @(posedge clk); #1;
    chk("R5 hold", {16'h0, elemEn}, {16'h0, held});
    chk("R5 pulse", {31'h0, patValid}, 32'h0);
  endtask

  task automatic sweep(bit inject);
    @(negedge clk);
    start = 1'b1; seqMode = 1'b1;
    @(posedge clk);
    for (int i = 0; i < N * P; i++) begin
      @(negedge clk);
      start   = inject && (i == 20 || i == 41);
      seqMode = (i != 41);
      codeIn  = 5'd3; sampleIn = 2'd2;
      @(posedge clk); #1;
      chk(inject ? "R8 pattern" : "R6 pattern", {16'h0, elemEn},
          {16'h0, expPat(1 + i / P, i % P)});
      chk("R6 valid", {31'h0, patValid}, 32'h1);
      chk("R7 done", {31'h0, done}, (i == N * P - 1) ? 32'h1 : 32'h0);
    end
    @(negedge clk);
    start = 1'b0; seqMode = 1'b0;
    @(posedge clk); #1;
    chk("R7 done held", {31'h0, done}, 32'h1);
    chk("R5 after sweep", {31'h0, patValid}, 32'h0);
    chk("R5 hold after sweep", {16'h0, elemEn}, {16'h0, expPat(N, P - 1)});
  endtask

  initial begin
    #1;
    chk("R1 elemEn", {16'h0, elemEn}, 32'h0);
    chk("R1 patValid", {31'h0, patValid}, 32'h0);
    chk("R1 done", {31'h0, done}, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    directReq(5, 1, "R9 example");
    chk("R9 value", {16'h0, elemEn}, 32'h0000_01F0);
    directReq(0, 3, "R3 zero");
    directReq(N, 2, "R3 full");
    directReq(31, 1, "R3 saturate");

    for (int k = 0; k < 32; k++)
      for (int s = 0; s < P; s++) directReq(k, s, "R2 sweep up");
    for (int k = 31; k >= 0; k--)
      for (int s = P - 1; s >= 0; s--) directReq(k, s, "R4 sweep down");

    sweep(1'b0);
    directReq(3, 3, "R7 clear");
    chk("R7 cleared", {31'h0, done}, 32'h0);
    sweep(1'b1);
    directReq(7, 2, "R4 after sweep");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule